// File: doc/BRIEF.md
# Single-Wire Byte Sequencer with Strong Pull-Up Hold

This block sits between a byte-level controller and a bit-slot engine on a single-wire open-drain bus. It takes one byte command at a time and turns it into eight slot requests. Bits always go out least significant bit first. Three operations are supported. A write drives the bits of a byte and discards what the bus returns. A read issues eight slots that drive a one and collects the sampled level of each slot. A touch drives each data bit and replaces that bit with the level sampled in the same slot.

Powered devices on such a bus sometimes need a strong pull-up right after the last bit of a write. The block keeps a one-shot request for this, stored as a duration in milliseconds. The request arms together with the eighth slot request of the next write. Once that write's last slot finishes, the block holds for the programmed time. During the hold it drives the pull-up enable if the pull-up is allowed, and it only waits if it is not. When the hold ends the request is cleared. A millisecond is counted as a parameterised number of clock cycles.

The command port uses a valid/ready handshake. A command transfers on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the block is idle, so a producer must hold its command until it is taken. There is no result back-pressure: `done` pulses for one cycle with `result`.

Top module: `w1_byte_seq`

## Requirements
- R1: Each command issues exactly eight slot requests. For write and touch, slot k drives bit k of `cmd_byte` on `slot_bit`, so the bits go out least significant bit first.
- R2: A read (`cmd_op` = 2'b01) drives `slot_bit` = 1 in all eight slots, and the sample returned in slot k lands in `result` bit k.
- R3: A touch (`cmd_op` = 2'b10) returns in `result` bit k the sample of slot k.
- R4: A write (`cmd_op` = 2'b00) discards the samples, and `result` is 0 when `done` pulses.
- R5: `slot_req` stays high, with `slot_bit` unchanged, until a cycle with `slot_ack`.
- R6: `cmd_ready` is high only when no slot and no hold is in progress. No command is taken between acceptance and `done`.
- R7: With a nonzero request pending and `pu_allow` high at acceptance, `spu_en` rises together with the eighth slot request of a write and is low during the first seven slots.
- R8: After the last slot of a write with a pending request, the block waits exactly `pu_ms` × CYC_PER_MS cycles before `done`. If the pull-up was allowed, `spu_en` stays high for the whole wait and falls in the `done` cycle.
- R9: If `pu_allow` was low at acceptance, the wait of R8 still takes place, but `spu_en` stays low.
- R10: A request is used by one write only. The following write has no wait and no pull-up.
- R11: Loading a duration of 0 cancels a pending request.
- R12: Read and touch commands neither use nor clear a pending request.
- R13: `pu_load` is ignored unless the block is idle.
- R14: `done` is a single-cycle pulse, and `result` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 2 | 00 write, 01 read, 10 touch, 11 treated as read |
| cmd_byte | input | BYTE_W | Data byte for write or touch |
| done | output | 1 | One-cycle completion pulse |
| result | output | BYTE_W | Collected byte, valid with done |
| pu_load | input | 1 | Load a pull-up request duration (idle only) |
| pu_ms | input | MS_W | Duration in milliseconds, 0 cancels |
| pu_allow | input | 1 | Strong pull-up may be driven, sampled at acceptance |
| slot_req | output | 1 | Slot request to the bit engine |
| slot_bit | output | 1 | Level to drive in the requested slot |
| slot_ack | input | 1 | Slot finished, one-cycle pulse |
| slot_sample | input | 1 | Bus level sampled in the finished slot |
| spu_en | output | 1 | Strong pull-up enable |

## Verification
The embedded assertions check the handshakes on every cycle: a slot request holds steady until it is acknowledged, the command port stays closed while a slot or a pull-up is active, the pull-up rises only with a slot request and falls only into a `done` pulse, `done` lasts one cycle, eight acknowledged slots precede each `done`, and a consumed request is gone the next cycle. Other properties need a whole sequence of commands and only the bench scenarios can show them: bit order and sample placement for each operation, the exact hold length in clock cycles, and the timing of the pull-up on the eighth slot. The same holds for the one-shot clearing, cancellation by a zero duration, survival of a request across reads and touches, and a load that is ignored while the block is busy.

// File: rtl/w1seq_pkg.sv
package w1seq_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_TOUCH = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SLOT = 2'd1,
    ST_HOLD = 2'd2,
    ST_DONE = 2'd3
  } st_e;
endpackage

// File: rtl/w1seq_shift.sv
// Bit shifter: presents the lsb for the next slot and gathers samples at the msb.
module w1seq_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              step,
  input  logic              capture_bit,
  output logic              lsb,
  output logic [BYTE_W-1:0] word
);
  logic [BYTE_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    sh_q <= '0;
    else if (load) sh_q <= load_val;
    else if (step) sh_q <= {capture_bit, sh_q[BYTE_W-1:1]};
  end

  assign lsb  = sh_q[0];
  assign word = sh_q;
endmodule

// File: rtl/w1seq_pu_req.sv
// One-shot pull-up request register: a nonzero duration means pending.
module w1seq_pu_req #(
  parameter int MS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [MS_W-1:0] load_ms,
  input  logic            consume,
  output logic            pending,
  output logic [MS_W-1:0] ms_out
);
  logic [MS_W-1:0] ms_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       ms_q <= '0;
    else if (consume) ms_q <= '0;
    else if (load_en) ms_q <= load_ms;
  end

  assign pending = |ms_q;
  assign ms_out  = ms_q;

  // R10: only a pending request can be consumed, and it is gone afterwards
  p_consume_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> pending);
  p_cleared_after_use_r10: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> !pending);
endmodule

// File: rtl/w1seq_ms_timer.sv
// Millisecond hold timer: counts ms_in whole milliseconds of CYC_PER_MS cycles.
module w1seq_ms_timer #(
  parameter int CYC_PER_MS = 100000,
  parameter int MS_W       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MS_W-1:0] ms_in,
  output logic            running,
  output logic            expire
);
  localparam int TICK_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(CYC_PER_MS - 1);

  logic [TICK_W-1:0] tick_q;
  logic [MS_W-1:0]   ms_left_q;
  logic              run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      tick_q    <= '0;
      ms_left_q <= '0;
    end else if (start) begin
      run_q     <= 1'b1;
      tick_q    <= '0;
      ms_left_q <= ms_in;
    end else if (run_q) begin
      if (tick_q == TICK_LAST) begin
        tick_q <= '0;
        if (ms_left_q == MS_W'(1)) run_q <= 1'b0;
        else                       ms_left_q <= ms_left_q - MS_W'(1);
      end else begin
        tick_q <= tick_q + TICK_W'(1);
      end
    end
  end

  assign running = run_q;
  assign expire  = run_q && (tick_q == TICK_LAST) && (ms_left_q == MS_W'(1));

  // R8: a hold starts only from rest and stops right after expiry
  p_start_at_rest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !running);
  p_stop_after_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !running);
endmodule

// File: rtl/w1_byte_seq.sv
module w1_byte_seq #(
  parameter int BYTE_W     = 8,
  parameter int MS_W       = 8,
  parameter int CYC_PER_MS = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [BYTE_W-1:0] cmd_byte,
  output logic              done,
  output logic [BYTE_W-1:0] result,
  input  logic              pu_load,
  input  logic [MS_W-1:0]   pu_ms,
  input  logic              pu_allow,
  output logic              slot_req,
  output logic              slot_bit,
  input  logic              slot_ack,
  input  logic              slot_sample,
  output logic              spu_en
);
  import w1seq_pkg::*;

  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  st_e             state_q;
  op_e             op_q;
  logic            allow_q;
  logic [IDX_W-1:0] bit_idx_q;

  logic            accept;
  logic            last_bit;
  logic            is_write;
  logic            ack_slot;
  logic            hold_go;
  logic            pend;
  logic [MS_W-1:0] pend_ms;
  logic            tmr_running;
  logic            tmr_expire;
  logic            use_req;
  logic            sh_lsb;
  logic [BYTE_W-1:0] sh_word;
  logic [BYTE_W-1:0] load_val;

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign last_bit  = (bit_idx_q == LAST_IDX);
  assign is_write  = (op_q == OP_WRITE);
  assign ack_slot  = (state_q == ST_SLOT) && slot_ack;
  assign hold_go   = ack_slot && last_bit && is_write && pend;
  assign use_req   = (state_q == ST_HOLD) && tmr_expire;
  assign load_val  = cmd_op[0] ? {BYTE_W{1'b1}} : cmd_byte;

  w1seq_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .load_val    (load_val),
    .step        (ack_slot),
    .capture_bit (is_write ? 1'b0 : slot_sample),
    .lsb         (sh_lsb),
    .word        (sh_word)
  );

  w1seq_pu_req #(.MS_W(MS_W)) u_pu_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (pu_load && (state_q == ST_IDLE)),
    .load_ms (pu_ms),
    .consume (use_req),
    .pending (pend),
    .ms_out  (pend_ms)
  );

  w1seq_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MS_W(MS_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (hold_go),
    .ms_in   (pend_ms),
    .running (tmr_running),
    .expire  (tmr_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_WRITE;
      allow_q   <= 1'b0;
      bit_idx_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q   <= ST_SLOT;
          op_q      <= op_e'(cmd_op);
          allow_q   <= pu_allow;
          bit_idx_q <= '0;
        end
        ST_SLOT: if (slot_ack) begin
          if (last_bit) state_q <= hold_go ? ST_HOLD : ST_DONE;
          else          bit_idx_q <= bit_idx_q + IDX_W'(1);
        end
        ST_HOLD: if (tmr_expire) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign slot_req = (state_q == ST_SLOT);
  assign slot_bit = sh_lsb;
  assign spu_en   = allow_q &&
                    (((state_q == ST_SLOT) && last_bit && is_write && pend) ||
                     (state_q == ST_HOLD));
  assign done     = (state_q == ST_DONE);
  assign result   = sh_word;

  // Checker-only count of acknowledged slots since acceptance
  logic [IDX_W:0] chk_acks_q;
  always_ff @(posedge clk) begin
    if (!rst_n)        chk_acks_q <= '0;
    else if (accept)   chk_acks_q <= '0;
    else if (ack_slot) chk_acks_q <= chk_acks_q + (IDX_W+1)'(1);
  end

  // R1: eight acknowledged slots before every completion
  p_eight_slots_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (chk_acks_q == (IDX_W+1)'(BYTE_W)));
  // R5: request held with a stable bit until acknowledged
  p_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && !slot_ack) |=> (slot_req && $stable(slot_bit)));
  // R6: no new command while a slot or the pull-up is active
  p_closed_when_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req || spu_en || tmr_running) |-> !cmd_ready);
  // R7: pull-up rises only alongside a slot request
  p_spu_rise_with_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spu_en) |-> slot_req);
  // R8: pull-up ends exactly into completion
  p_spu_fall_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spu_en) |-> done);
  // R14: completion is a single-cycle pulse
  p_done_pulse_r14: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/w1_byte_seq_bench.sv
`timescale 1ns/1ps
module w1_byte_seq_bench;
  localparam int CYC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_byte = 8'd0;
  logic       done;
  logic [7:0] result;
  logic       pu_load = 1'b0;
  logic [7:0] pu_ms = 8'd0;
  logic       pu_allow = 1'b1;
  logic       slot_req;
  logic       slot_bit;
  logic       slot_ack = 1'b0;
  logic       slot_sample = 1'b0;
  logic       spu_en;

  always #4 clk = ~clk;

  w1_byte_seq #(.BYTE_W(8), .MS_W(8), .CYC_PER_MS(CYC)) u_w1_byte_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .done(done), .result(result),
    .pu_load(pu_load), .pu_ms(pu_ms), .pu_allow(pu_allow),
    .slot_req(slot_req), .slot_bit(slot_bit), .slot_ack(slot_ack),
    .slot_sample(slot_sample), .spu_en(spu_en)
  );

  int checks = 0;
  int errors = 0;
  int kidx = 0;
  int wait_cnt = 0;
  int spu_cnt = 0;
  int ready_cnt = 0;
  logic in_cmd = 1'b0;
  logic [7:0] bus_byte = 8'hFF;
  logic [7:0] sent = 8'd0;
  logic [7:0] spu_at = 8'd0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bit-engine model: wired-AND of driven bit and the device's bus byte
  initial begin
    forever begin
      @(negedge clk);
      if (slot_req) begin
        repeat (2) @(negedge clk);
        if (kidx < 8) begin
          sent[kidx[2:0]]   = slot_bit;
          spu_at[kidx[2:0]] = spu_en;
          slot_sample       = slot_bit & bus_byte[kidx[2:0]];
        end
        slot_ack = 1'b1;
        @(negedge clk);
        slot_ack = 1'b0;
        kidx = kidx + 1;
      end
    end
  end

  // Phase monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!cmd_ready && !slot_req && !done) wait_cnt++;
        if (spu_en && !slot_req) spu_cnt++;
        if (in_cmd && cmd_ready) ready_cnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic load_pu(input logic [7:0] m);
    @(negedge clk);
    pu_load = 1'b1;
    pu_ms = m;
    @(negedge clk);
    pu_load = 1'b0;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] data, input logic [7:0] bus,
                         input logic [7:0] exp_res, input int exp_wait, input int exp_spu,
                         input logic exp_pu7, input logic [7:0] busy_pu);
    logic [7:0] got;
    string rtag;
    @(negedge clk);
    kidx = 0; bus_byte = bus; wait_cnt = 0; spu_cnt = 0; ready_cnt = 0;
    spu_at = 8'd0; sent = 8'd0;
    cmd_op = op; cmd_byte = data; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    in_cmd = 1'b1;
    if (busy_pu != 8'd0) begin
      pu_load = 1'b1; pu_ms = busy_pu;
      @(negedge clk);
      pu_load = 1'b0;
    end
    while (!done) @(negedge clk);
    got = result;
    in_cmd = 1'b0;
    @(negedge clk);
    rtag = (op == 2'd0) ? "R4 write result" : (op == 2'd2) ? "R3 touch result" : "R2 read result";
    chk(rtag, {24'd0, got}, {24'd0, exp_res});
    chk((op == 2'd1) ? "R2 read drives ones" : "R1 lsb-first bits",
        {24'd0, sent}, {24'd0, (op == 2'd1) ? 8'hFF : data});
    chk("R1 eight slots", kidx, 8);
    chk("R8 R9 hold cycles", wait_cnt, exp_wait);
    chk("R8 R9 pull-up cycles", spu_cnt, exp_spu);
    chk("R7 pull-up at eighth slot only", {24'd0, spu_at}, {24'd0, exp_pu7 ? 8'h80 : 8'h00});
    chk("R6 not ready while busy", ready_cnt, 0);
  endtask

  // {op[34:33], data[32:25], bus[24:17], ms[16:9], allow[8], exp_result[7:0]}
  localparam logic [34:0] VEC [8] = '{
    {2'd0, 8'hA5, 8'hFF, 8'd0, 1'b1, 8'h00},
    {2'd1, 8'h00, 8'h3C, 8'd0, 1'b1, 8'h3C},
    {2'd2, 8'hF0, 8'h96, 8'd0, 1'b1, 8'h90},
    {2'd0, 8'h81, 8'hFF, 8'd2, 1'b1, 8'h00},
    {2'd0, 8'h7E, 8'hFF, 8'd3, 1'b0, 8'h00},
    {2'd2, 8'h5A, 8'hFF, 8'd0, 1'b1, 8'h5A},
    {2'd1, 8'h00, 8'h01, 8'd0, 1'b1, 8'h01},
    {2'd0, 8'h00, 8'hFF, 8'd1, 1'b1, 8'h00}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 ready after reset", {31'd0, cmd_ready}, 32'd1);
    chk("R5 no slot after reset", {31'd0, slot_req}, 32'd0);
    chk("R8 no pull-up after reset", {31'd0, spu_en}, 32'd0);
    chk("R14 no done after reset", {31'd0, done}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      logic [1:0] op;
      logic [7:0] m;
      logic al;
      int w;
      op = VEC[i][34:33];
      m  = VEC[i][16:9];
      al = VEC[i][8];
      w  = (op == 2'd0 && m != 8'd0) ? int'(m) * CYC : 0;
      pu_allow = al;
      if (m != 8'd0) load_pu(m);
      run_cmd(op, VEC[i][32:25], VEC[i][24:17], VEC[i][7:0], w, al ? w : 0,
              al && (w > 0), 8'd0);
    end
    pu_allow = 1'b1;

    // R10: one-shot
    load_pu(8'd2);
    run_cmd(2'd0, 8'h3C, 8'hFF, 8'h00, 2*CYC, 2*CYC, 1'b1, 8'd0);
    run_cmd(2'd0, 8'hC3, 8'hFF, 8'h00, 0, 0, 1'b0, 8'd0);   // R10 cleared

    // R11: zero duration cancels
    load_pu(8'd3);
    load_pu(8'd0);
    run_cmd(2'd0, 8'h69, 8'hFF, 8'h00, 0, 0, 1'b0, 8'd0);   // R11

    // R12: read and touch keep the request pending
    load_pu(8'd1);
    run_cmd(2'd1, 8'h00, 8'h5A, 8'h5A, 0, 0, 1'b0, 8'd0);   // R12
    run_cmd(2'd2, 8'h0F, 8'hFF, 8'h0F, 0, 0, 1'b0, 8'd0);   // R12
    run_cmd(2'd0, 8'h11, 8'hFF, 8'h00, CYC, CYC, 1'b1, 8'd0); // R12 still pending

    // R13: load while busy is ignored
    run_cmd(2'd0, 8'h22, 8'hFF, 8'h00, 0, 0, 1'b0, 8'd4);   // R13
    run_cmd(2'd0, 8'h44, 8'hFF, 8'h00, 0, 0, 1'b0, 8'd0);   // R13

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule